// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Commit

This unit sits between a two-wire memory protocol engine and an 8192-byte storage array. The array is arranged as 256 pages of 32 bytes. A write command gives a 13-bit starting address. The unit then gathers data bytes into a one-page staging buffer and notes which slots received a byte. Nothing reaches the array while bytes are still arriving.

When a STOP arrives after at least one byte, and write protection is off, the unit sends one array write for each marked slot. It then keeps its busy flag high for a programmed interval, counted in system clocks. While busy, it ignores every command. A START or abort before the STOP discards the gathered bytes.

Data enters on a valid/ready stream and leaves toward the array on a second valid/ready stream. On the input side, `in_ready` is high exactly while the unit is collecting, and it never depends on `in_valid`. On the array side, the array may stall by holding `aw_ready` low. Once `aw_valid` is raised, it stays high with address and data unchanged until `aw_ready` accepts the beat. The `next_addr` output is the shared current-address value that the read path continues from.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy`, `in_ready` and `aw_valid` are low and `next_addr` is 0.
- R2: A `wr_start` pulse while idle loads `start_addr` into `next_addr` and raises `in_ready` from the next cycle.
- R3: Each accepted byte advances only `next_addr[4:0]`, wrapping from 31 to 0. Bits [12:5] (the page) never change.
- R4: When more than 32 bytes arrive, a later byte replaces the earlier byte in the same slot. The commit writes each slot once, with its latest value.
- R5: The commit writes only slots that received a byte, in ascending slot order (0 to 31), at address {page, slot}. Other slots get no write.
- R6: An `abort`, or a STOP with no byte received, produces no array write and no busy, and leaves `next_addr` unchanged.
- R7: A STOP after at least one byte, with `wp` low, raises `busy` in the next cycle. `busy` stays high through the commit and then for exactly PROG_CYCLES cycles after the last accepted array write.
- R8: While `busy` is high, `in_ready` is low and `wr_start`, `stop`, `abort` and `in_valid` have no effect on `next_addr` or on array writes.
- R9: If `wp` is high at the STOP, bytes are still accepted, but there are no array writes and `busy` stays low. `next_addr` still reflects the bytes received.
- R10: While `aw_valid` is high and `aw_ready` is low, `aw_valid`, `aw_addr` and `aw_data` hold steady in the next cycle.
- R11: A byte accepted in the same cycle as the STOP is part of the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Begin a write command at `start_addr` |
| start_addr | input | 13 | Starting byte address of the write |
| stop | input | 1 | STOP seen on the bus |
| abort | input | 1 | New START before STOP: discard buffered bytes |
| wp | input | 1 | Write protect, high blocks programming |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Unit accepts a data byte |
| in_data | input | 8 | Data byte |
| aw_valid | output | 1 | Array write beat valid |
| aw_ready | input | 1 | Array accepts the write beat |
| aw_addr | output | 13 | Array write address |
| aw_data | output | 8 | Array write data |
| busy | output | 1 | Commit or programming interval in progress |
| next_addr | output | 13 | Current address counter |

## Verification
A corrupted slot mask would show up at the array port right after the STOP. Beats would appear for slots that were never written, or be missing, or arrive out of ascending order. A wrong in-page counter would show on `next_addr` one cycle after the offending byte, and again in the commit addresses. A timer or state fault would show as a busy window whose length differs from the slot count plus PROG_CYCLES, or as `in_ready` rising while busy. Commands sent during busy must leave the write log and `next_addr` unchanged.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_PROG   = 2'd3
  } pcu_state_t;
endpackage

// File: rtl/pcu_slot_store.sv
module pcu_slot_store #(
  parameter int SLOTS  = 32,
  parameter int DATA_W = 8,
  localparam int OFF_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              drain,
  output logic              any_set,
  output logic              last_one,
  output logic [OFF_W-1:0]  sel_slot,
  output logic [DATA_W-1:0] sel_data
);
  logic [SLOTS-1:0]  mark_q;
  logic [DATA_W-1:0] byte_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
      for (int i = 0; i < SLOTS; i++) byte_q[i] <= '0;
    end else if (clear) begin
      mark_q <= '0;
    end else begin
      if (drain) mark_q[sel_slot] <= 1'b0;
      if (wr_en) begin
        mark_q[wr_slot] <= 1'b1;
        byte_q[wr_slot] <= wr_data;
      end
    end
  end

  // lowest marked slot wins
  always_comb begin
    sel_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mark_q[i]) sel_slot = OFF_W'(i);
    end
  end

  assign sel_data = byte_q[sel_slot];
  assign any_set  = |mark_q;
  assign last_one = any_set && ((mark_q & (mark_q - 1'b1)) == '0);

  p_drain_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> any_set);
  p_drain_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !wr_en && !clear) |=> !mark_q[$past(sel_slot)]);
endmodule

// File: rtl/pcu_prog_timer.sv
module pcu_prog_timer #(
  parameter int CYCLES = 250000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= CW'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < CW'(CYCLES)));
  p_expire_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> !run_q);
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 250000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              stop,
  input  logic              abort,
  input  logic              wp,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [DATA_W-1:0] aw_data,
  output logic              busy,
  output logic [ADDR_W-1:0] next_addr
);
  import pcu_pkg::*;

  pcu_state_t        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  logic accept, drain, clear, load_tmr;
  logic any_set, last_one, expired;
  logic [OFF_W-1:0] sel_slot;

  assign in_ready = (state_q == ST_FILL);
  assign accept   = in_valid && in_ready;
  assign busy     = (state_q == ST_COMMIT) || (state_q == ST_PROG);
  assign aw_valid = (state_q == ST_COMMIT);
  assign drain    = aw_valid && aw_ready;
  assign clear    = wr_start && ((state_q == ST_IDLE) || (state_q == ST_FILL));
  assign load_tmr = drain && last_one;
  assign aw_addr  = {page_q, sel_slot};
  assign next_addr = {page_q, off_q};

  pcu_slot_store #(.SLOTS(PAGE_BYTES), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .wr_en    (accept && !wr_start),
    .wr_slot  (off_q),
    .wr_data  (in_data),
    .drain    (drain),
    .any_set  (any_set),
    .last_one (last_one),
    .sel_slot (sel_slot),
    .sel_data (aw_data)
  );

  pcu_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_tmr),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_start) begin
            page_q  <= start_addr[ADDR_W-1:OFF_W];
            off_q   <= start_addr[OFF_W-1:0];
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (wr_start) begin
            page_q <= start_addr[ADDR_W-1:OFF_W];
            off_q  <= start_addr[OFF_W-1:0];
          end else begin
            if (accept) off_q <= off_q + OFF_W'(1);
            if (abort) state_q <= ST_IDLE;
            else if (stop)
              state_q <= ((any_set || accept) && !wp) ? ST_COMMIT : ST_IDLE;
          end
        end
        ST_COMMIT: begin
          if (load_tmr) state_q <= ST_PROG;
        end
        ST_PROG: begin
          if (expired) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_hold_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr) && $stable(aw_data)));
  p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wp && stop));
  p_in_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wr_start) |=>
      (next_addr[ADDR_W-1:OFF_W] == $past(next_addr[ADDR_W-1:OFF_W])) &&
      (next_addr[OFF_W-1:0] == $past(next_addr[OFF_W-1:0]) + OFF_W'(1)));
  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(next_addr));
endmodule

// File: tb/tb_page_commit_unit.sv
module tb_page_commit_unit;
  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_start = 1'b0, stop = 1'b0, abort = 1'b0, wp = 1'b0;
  logic [12:0] start_addr = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        aw_ready = 1'b1;
  logic        in_ready, aw_valid, busy;
  logic [12:0] aw_addr, next_addr;
  logic [7:0]  aw_data;

  int total = 0, bad = 0;
  int wn = 0;
  logic [12:0] wa [64];
  logic [7:0]  wd [64];
  logic stall = 1'b0;

  always #10 clk = ~clk;

  page_commit_unit #(.PROG_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .start_addr(start_addr),
    .stop(stop), .abort(abort), .wp(wp), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .aw_valid(aw_valid),
    .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_data(aw_data),
    .busy(busy), .next_addr(next_addr)
  );

  // array side: drive ready and log handshakes that complete at the next edge
  always @(negedge clk) begin
    aw_ready = stall ? ~aw_ready : 1'b1;
    if (aw_valid && aw_ready && wn < 64) begin
      wa[wn] = aw_addr;
      wd[wn] = aw_data;
      wn++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_write(input logic [12:0] a);
    @(negedge clk); wn = 0; wr_start = 1'b1; start_addr = a;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
  endtask

  // pulse stop, then count busy cycles until idle
  task automatic finish_write(output int bc);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    bc = 0;
    while (busy && bc < 5000) begin bc++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 in_ready", in_ready, 0);
    check("R1 aw_valid", aw_valid, 0);
    check("R1 next_addr", next_addr, 0);
  endtask

  task automatic t_single();
    int bc;
    begin_write(13'h1234);
    check("R2 in_ready", in_ready, 1);
    check("R2 next_addr", next_addr, 13'h1234);
    put_byte(8'hA5);
    check("R3 next_addr", next_addr, 13'h1235);
    finish_write(bc);
    check("R7 busy length", bc, 1 + P);
    check("R5 count", wn, 1);
    check("R5 addr", wa[0], 13'h1234);
    check("R5 data", wd[0], 8'hA5);
    check("R7 busy low", busy, 0);
  endtask

  task automatic t_wrap_partial();
    int bc;
    begin_write(13'h003E);
    for (int i = 0; i < 4; i++) put_byte(8'h10 + 8'(i));
    check("R3 wrap next_addr", next_addr, 13'h0022);
    finish_write(bc);
    check("R5 count", wn, 4);
    check("R5 a0", wa[0], 13'h0020); check("R5 d0", wd[0], 8'h12);
    check("R5 a1", wa[1], 13'h0021); check("R5 d1", wd[1], 8'h13);
    check("R5 a2", wa[2], 13'h003E); check("R5 d2", wd[2], 8'h10);
    check("R5 a3", wa[3], 13'h003F); check("R5 d3", wd[3], 8'h11);
    check("R7 busy length", bc, 4 + P);
  endtask

  task automatic t_overflow_stall();
    int bc;
    stall = 1'b1;
    begin_write(13'h0100);
    for (int i = 0; i < 34; i++) put_byte(8'(i));
    check("R3 next_addr", next_addr, 13'h0102);
    finish_write(bc);
    stall = 1'b0;
    check("R4 count", wn, 32);
    for (int k = 0; k < 32; k++) begin
      check("R4 addr", wa[k], 13'h0100 + k);
      check("R4 data", wd[k], (k < 2) ? k + 32 : k);
    end
    check("R10 busy stretched", int'(bc > 32 + P), 1);
  endtask

  task automatic t_abort_empty();
    begin_write(13'h0440);
    put_byte(8'h01); put_byte(8'h02); put_byte(8'h03);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    repeat (3) begin
      check("R6 abort busy", busy, 0);
      @(negedge clk);
    end
    check("R6 abort writes", wn, 0);
    check("R6 abort next_addr", next_addr, 13'h0443);
    begin_write(13'h00AB);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    repeat (3) begin
      check("R6 empty busy", busy, 0);
      @(negedge clk);
    end
    check("R6 empty writes", wn, 0);
    check("R6 empty next_addr", next_addr, 13'h00AB);
  endtask

  task automatic t_protect();
    int bc;
    wp = 1'b1;
    begin_write(13'h0800);
    check("R9 in_ready", in_ready, 1);
    put_byte(8'h5A); put_byte(8'h6B);
    finish_write(bc);
    check("R9 busy cycles", bc, 0);
    repeat (3) @(negedge clk);
    check("R9 writes", wn, 0);
    check("R9 next_addr", next_addr, 13'h0802);
    wp = 1'b0;
  endtask

  task automatic t_busy_ignore();
    int bc;
    begin_write(13'h0A00);
    put_byte(8'hC3);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 in_ready", in_ready, 0);
    check("R8 busy", busy, 1);
    wr_start = 1'b1; start_addr = 13'h1FFF; in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    stop = 1'b1; abort = 1'b1;
    @(negedge clk);
    wr_start = 1'b0; in_valid = 1'b0; stop = 1'b0; abort = 1'b0;
    bc = 0;
    while (busy && bc < 5000) begin bc++; @(negedge clk); end
    @(negedge clk);
    check("R8 writes", wn, 1);
    check("R8 next_addr", next_addr, 13'h0A01);
    check("R8 idle in_ready", in_ready, 0);
  endtask

  task automatic t_same_cycle();
    int bc;
    begin_write(13'h0500);
    in_valid = 1'b1; in_data = 8'h77; stop = 1'b1;
    @(negedge clk); in_valid = 1'b0; stop = 1'b0;
    bc = 0;
    while (busy && bc < 5000) begin bc++; @(negedge clk); end
    check("R11 count", wn, 1);
    check("R11 addr", wa[0], 13'h0500);
    check("R11 data", wd[0], 8'h77);
    check("R11 next_addr", next_addr, 13'h0501);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_wrap_partial();
    t_overflow_stall();
    t_abort_empty();
    t_protect();
    t_busy_ignore();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule